// File: doc/BRIEF.md
# Load/Store Address Generator

This block forms the memory address for a single-register load or store. A transfer request carries the current value of the base register, an offset that is either an immediate or an index register already passed through the shifter, the number of the base register, and four control bits. They select pre- or post-indexing, adding or subtracting the offset, base writeback in pre-indexed mode, and byte or 32-bit word access. From these the block computes the effective address and the new base value. It then presents the access to a memory port as a 26-bit bus address.

Requests enter on a valid/ready stream and sit in a single output register that drives the memory port, which is also valid/ready. A request is taken when `req_valid` and `req_ready` are both high. The request slot frees when the memory takes the held access, so `req_ready` is high whenever the slot is empty or `mem_ready` is high. While `mem_valid` is high and `mem_ready` is low, every output of the held access stays frozen and no new request is taken. The base update for the register file comes out on plain pins as a one-cycle enable with its register number and value. That enable rises in the same cycle the memory accepts the access.

Top module: `ls_addr_unit`

## Requirements
- R1: In pre-indexed mode (`req_pre`=1) the effective address `acc_addr` is the base combined with the offset.
- R2: With `req_up`=1 the offset is added to the base and with `req_up`=0 it is subtracted, both modulo 2^32. This applies to the effective address and to the new base value.
- R3: In post-indexed mode (`req_pre`=0) the effective address is the unmodified base.
- R4: In pre-indexed mode the base is written back only when `req_wback`=1, and the value written is base combined with offset.
- R5: In post-indexed mode the base is always written back with base combined with offset, whatever `req_wback` is.
- R6: When the base register number is 15, no writeback takes place in either mode.
- R7: `mem_addr` carries bits [25:0] of the effective address, and `acc_addr` carries all 32 bits.
- R8: `mem_byte` follows the request's byte flag. `mem_misalign` is 1 only for a word access whose address bits [1:0] are nonzero, and it is never 1 for a byte access. The address is driven unchanged in every case.
- R9: `wb_en` is high for exactly one cycle, the cycle in which `mem_valid` and `mem_ready` are both high for that access, with `wb_idx` and `wb_value` valid in that cycle.
- R10: While `mem_valid`=1 and `mem_ready`=0, the held access and its writeback data stay stable, `req_ready` is 0 and `wb_en` is 0. `req_ready` is 1 whenever the slot is empty or `mem_ready` is 1.
- R11: After reset `mem_valid` and `wb_en` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request slot can take a request |
| req_base | input | 32 | Current base register value |
| req_offset | input | 32 | Immediate or shifted index offset |
| req_base_idx | input | 4 | Base register number |
| req_pre | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| req_up | input | 1 | 1 = add offset, 0 = subtract offset |
| req_wback | input | 1 | Base writeback request for pre-indexed mode |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| mem_valid | output | 1 | Access presented to memory |
| mem_ready | input | 1 | Memory takes the access |
| mem_addr | output | 26 | Bus address |
| mem_byte | output | 1 | Byte access indication |
| mem_misalign | output | 1 | Word access with nonzero low address bits |
| acc_addr | output | 32 | Full effective address |
| wb_en | output | 1 | Base writeback pulse |
| wb_idx | output | 4 | Register number to write back |
| wb_value | output | 32 | Updated base value |

## Verification
The retirement of one access, which raises the base writeback pulse, can fall in the same cycle as the acceptance of the next request into the freed slot. The bench provokes this by holding `mem_ready` low while a first access is held and a second request waits at the input, then raising `mem_ready`. It judges the result by seeing the first access's writeback number and value in the release cycle. In the following cycle the second access's address and writeback appear, and the cycle after that has no pulse, which shows that neither writeback was lost or repeated.

// File: rtl/ls_addr_pkg.sv
package ls_addr_pkg;

  // control bits of one single-register transfer
  typedef struct packed {
    logic pre;      // 1: address = base +/- offset, 0: address = base
    logic up;       // 1: add, 0: subtract
    logic wback;    // writeback request (pre-indexed only)
    logic byte_sel; // byte instead of word
  } xfer_ctl_t;

  localparam int XFER_CTL_W = $bits(xfer_ctl_t);

endpackage

// File: rtl/ls_offset_adder.sv
module ls_offset_adder #(
  parameter int W          = 32,
  parameter bit INVERT_ADD = 1'b1
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  input  logic         up,
  output logic [W-1:0] result
);

  generate
    if (INVERT_ADD) begin : g_single_adder
      // one carry chain: base + ~offset + 1 when subtracting
      logic [W-1:0] opnd;
      always_comb begin
        opnd   = up ? offset : ~offset;
        result = base + opnd + {{(W-1){1'b0}}, ~up};
      end
    end else begin : g_dual_adder
      logic [W-1:0] sum_add;
      logic [W-1:0] sum_sub;
      always_comb begin
        sum_add = base + offset;
        sum_sub = base - offset;
        result  = up ? sum_add : sum_sub;
      end
    end
  endgenerate

endmodule

// File: rtl/ls_wb_policy.sv
module ls_wb_policy #(
  parameter int IDX_W  = 4,
  parameter int PC_IDX = 15
) (
  input  logic [IDX_W-1:0] base_idx,
  input  logic             pre,
  input  logic             wback,
  output logic             wb_req
);

  localparam logic [IDX_W-1:0] PC_CODE = IDX_W'(PC_IDX);

  logic mode_wants_wb;
  logic idx_is_pc;

  always_comb begin
    // post-indexing always updates; pre-indexing only on request
    mode_wants_wb = !pre || wback;
    idx_is_pc     = (base_idx == PC_CODE);
    wb_req        = mode_wants_wb && !idx_is_pc;
  end

endmodule

// File: rtl/ls_hold_stage.sv
module ls_hold_stage #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [PW-1:0] out_data
);

  logic take;

  always_comb begin
    in_ready = !out_valid || out_ready;
    take     = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_data  <= in_data;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: rtl/ls_addr_unit.sv
module ls_addr_unit
  import ls_addr_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int BUS_AW     = 26,
  parameter int IDX_W      = 4,
  parameter int PC_IDX     = 15,
  parameter int WORD_BYTES = 4,
  parameter bit INVERT_ADD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_base,
  input  logic [DATA_W-1:0] req_offset,
  input  logic [IDX_W-1:0]  req_base_idx,
  input  logic              req_pre,
  input  logic              req_up,
  input  logic              req_wback,
  input  logic              req_byte,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [BUS_AW-1:0] mem_addr,
  output logic              mem_byte,
  output logic              mem_misalign,
  output logic [DATA_W-1:0] acc_addr,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_value
);

  localparam int ALIGN_W = $clog2(WORD_BYTES);
  // payload: eff addr, byte, misalign, wb request, idx, new base
  localparam int PW = DATA_W + 1 + 1 + 1 + IDX_W + DATA_W;

  xfer_ctl_t         ctl;
  logic [DATA_W-1:0] moved_base;
  logic [DATA_W-1:0] eff_addr;
  logic              wb_req;
  logic              misalign;
  logic [PW-1:0]     pay_in;
  logic [PW-1:0]     pay_out;
  logic              held_wb;

  always_comb begin
    ctl.pre      = req_pre;
    ctl.up       = req_up;
    ctl.wback    = req_wback;
    ctl.byte_sel = req_byte;
  end

  ls_offset_adder #(
    .W          (DATA_W),
    .INVERT_ADD (INVERT_ADD)
  ) i_adder (
    .base   (req_base),
    .offset (req_offset),
    .up     (ctl.up),
    .result (moved_base)
  );

  ls_wb_policy #(
    .IDX_W  (IDX_W),
    .PC_IDX (PC_IDX)
  ) i_policy (
    .base_idx (req_base_idx),
    .pre      (ctl.pre),
    .wback    (ctl.wback),
    .wb_req   (wb_req)
  );

  always_comb begin
    eff_addr = ctl.pre ? moved_base : req_base;
    misalign = !ctl.byte_sel && (|eff_addr[ALIGN_W-1:0]);
    pay_in   = {eff_addr, ctl.byte_sel, misalign, wb_req, req_base_idx, moved_base};
  end

  ls_hold_stage #(
    .PW (PW)
  ) i_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (mem_valid),
    .out_ready (mem_ready),
    .out_data  (pay_out)
  );

  always_comb begin
    {acc_addr, mem_byte, mem_misalign, held_wb, wb_idx, wb_value} = pay_out;
    mem_addr = acc_addr[BUS_AW-1:0];
    wb_en    = mem_valid && mem_ready && held_wb;
  end

  // R6
  no_pc_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_idx != IDX_W'(PC_IDX)));

  // R8
  byte_never_misaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_misalign |-> !mem_byte);

  // R10
  no_wb_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |-> !wb_en);

  // R7
  bus_addr_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr == acc_addr[BUS_AW-1:0]));

endmodule

// File: tb/test_ls_addr_unit.sv
module test_ls_addr_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [31:0] req_offset = '0;
  logic [3:0]  req_base_idx = '0;
  logic        req_pre = 1'b0;
  logic        req_up = 1'b0;
  logic        req_wback = 1'b0;
  logic        req_byte = 1'b0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic [25:0] mem_addr;
  logic        mem_byte;
  logic        mem_misalign;
  logic [31:0] acc_addr;
  logic        wb_en;
  logic [3:0]  wb_idx;
  logic [31:0] wb_value;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ls_addr_unit i_ls_addr_unit (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready),
    .req_base (req_base), .req_offset (req_offset), .req_base_idx (req_base_idx),
    .req_pre (req_pre), .req_up (req_up), .req_wback (req_wback), .req_byte (req_byte),
    .mem_valid (mem_valid), .mem_ready (mem_ready), .mem_addr (mem_addr),
    .mem_byte (mem_byte), .mem_misalign (mem_misalign), .acc_addr (acc_addr),
    .wb_en (wb_en), .wb_idx (wb_idx), .wb_value (wb_value)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] off;
    logic [3:0]  idx;
    logic        pre;
    logic        up;
    logic        wback;
    logic        byt;
    logic [31:0] exp_addr;
    logic        exp_we;
    logic [31:0] exp_val;
    logic        exp_mis;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    // R1 R4: pre, add, no writeback
    '{32'h0000_1000, 32'h10, 4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_1010, 1'b0, 32'h0, 1'b0},
    // R4: pre with writeback
    '{32'h0000_1000, 32'h10, 4'd2, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_1010, 1'b1, 32'h0000_1010, 1'b0},
    // R2: pre, subtract, writeback
    '{32'h0000_1000, 32'h20, 4'd5, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0000_0FE0, 1'b1, 32'h0000_0FE0, 1'b0},
    // R3 R5: post, add, wback bit clear still writes
    '{32'h0000_2000, 32'h4, 4'd7, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_2000, 1'b1, 32'h0000_2004, 1'b0},
    // R6: post with base 15 suppressed
    '{32'h0000_2000, 32'h8, 4'd15, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_2000, 1'b0, 32'h0, 1'b0},
    // R6 R8: pre writeback base 15, byte at odd address
    '{32'h0000_3001, 32'h2, 4'd15, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_3003, 1'b0, 32'h0, 1'b0},
    // R8: word misaligned
    '{32'h0000_4000, 32'h2, 4'd1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0000_4002, 1'b0, 32'h0, 1'b1},
    // R2: wrap modulo 2^32
    '{32'hFFFF_FFFC, 32'h8, 4'd3, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0000_0004, 1'b1, 32'h0000_0004, 1'b0},
    // R7: bits above 25 dropped on bus
    '{32'h0BFF_FF00, 32'h100, 4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0C00_0000, 1'b0, 32'h0, 1'b0},
    // R3 R5 R8: post, subtract, byte
    '{32'h0000_5003, 32'h1, 4'd3, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_5003, 1'b1, 32'h0000_5002, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [31:0] o, input logic [3:0] ix,
                       input logic p, input logic u, input logic w, input logic by);
    req_base = b; req_offset = o; req_base_idx = ix;
    req_pre = p; req_up = u; req_wback = w; req_byte = by;
    req_valid = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 mem_valid", 64'(mem_valid), 64'd0);
    check("R11 wb_en", 64'(wb_en), 64'd0);
    check("R11 req_ready", 64'(req_ready), 64'd1);
    rst_n = 1'b1;

    // table walk, memory always ready
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].base, VECS[i].off, VECS[i].idx, VECS[i].pre, VECS[i].up,
            VECS[i].wback, VECS[i].byt);
      @(negedge clk);
      req_valid = 1'b0;
      check("R1 R3 acc_addr", 64'(acc_addr), 64'(VECS[i].exp_addr));
      check("R7 mem_addr", 64'(mem_addr), 64'(VECS[i].exp_addr[25:0]));
      check("R8 mem_byte", 64'(mem_byte), 64'(VECS[i].byt));
      check("R8 mem_misalign", 64'(mem_misalign), 64'(VECS[i].exp_mis));
      check("R4 R5 R6 wb_en", 64'(wb_en), 64'(VECS[i].exp_we));
      if (VECS[i].exp_we) begin
        check("R2 R9 wb_value", 64'(wb_value), 64'(VECS[i].exp_val));
        check("R9 wb_idx", 64'(wb_idx), 64'(VECS[i].idx));
      end
    end
    @(negedge clk);
    check("R9 slot empties", 64'(mem_valid), 64'd0);

    // R10: back-pressure, then release overlapping with next acceptance
    mem_ready = 1'b0;
    drive(32'h100, 32'h4, 4'd1, 1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R10 held valid", 64'(mem_valid), 64'd1);
    check("R10 no wb while stalled", 64'(wb_en), 64'd0);
    check("R10 req_ready low", 64'(req_ready), 64'd0);
    drive(32'h200, 32'h8, 4'd2, 1'b0, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 addr stable", 64'(acc_addr), 64'h104);
    check("R10 still no wb", 64'(wb_en), 64'd0);
    mem_ready = 1'b1;
    #1;
    check("R9 release pulse", 64'(wb_en), 64'd1);
    check("R9 first value", 64'(wb_value), 64'h104);
    check("R9 first idx", 64'(wb_idx), 64'd1);
    check("R10 ready on release", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 second addr", 64'(acc_addr), 64'h200);
    check("R5 second wb_en", 64'(wb_en), 64'd1);
    check("R5 second value", 64'(wb_value), 64'h208);
    check("R9 second idx", 64'(wb_idx), 64'd2);
    @(negedge clk);
    check("R9 pulse ends", 64'(wb_en), 64'd0);
    check("R10 drained", 64'(mem_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule